// File: doc/BRIEF.md
# Receive FIFO with Drain Request

This block buffers words arriving from a serial receiver until the CPU or a DMA engine collects them. The receiver side pushes one word per cycle. The consumer side pops one word per cycle, and each popped word appears on a registered output together with a one-cycle valid strobe.

Once the buffer holds 12 words, a level-sensitive drain request goes up. The buffer is 20 entries deep, so at that level 8 free slots are still left. This lets a consumer that removes at most eight words per request respond without the buffer overrunning.

The drain request always drives the DMA request line. It drives the interrupt line only while the interrupt enable input is high. The request clears by itself once the buffer has been drained far enough; software does not acknowledge it. A separate not-empty flag lets a polling reader that has already taken its first eight words check whether more data is waiting before each further read.

Top module: `rx_fifo_sreq`

## Requirements
- R1: After reset the FIFO is empty, and `not_empty_o`, `sreq_o`, `dma_req_o`, `irq_o`, `overrun_o` and `pop_valid_o` are all low.
- R2: Words leave in the order they were accepted, and up to 20 words can be held. A pop that finds data drives that word on `pop_data_o`, with `pop_valid_o` high for one cycle, after the clock edge that takes the pop.
- R3: `sreq_o` goes high after the edge at which the occupancy reaches 12, and it stays high while the occupancy is 12 or more.
- R4: `sreq_o` goes low after the edge at which the occupancy falls to 11, which means at least nine slots are free.
- R5: `dma_req_o` equals `sreq_o` at all times, whatever the value of `irq_en_i`.
- R6: `irq_o` is high exactly when `sreq_o` and `irq_en_i` are both high. A change on `irq_en_i` takes effect in the same cycle.
- R7: `not_empty_o` is high after any edge that leaves at least one word stored, and low otherwise.
- R8: A push into a full FIFO without a pop in the same cycle is dropped. It leaves the stored words unchanged and raises `overrun_o` for exactly one cycle.
- R9: A pop from an empty FIFO changes no state. `pop_valid_o` stays low and `pop_data_o` keeps its previous value.
- R10: A push and a pop in the same cycle on a full FIFO are both accepted. The occupancy stays at 20 and no overrun is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Push request from the receiver |
| push_data_i | input | DATA_W | Word to store |
| pop_i | input | 1 | Pop request from the consumer |
| pop_data_o | output | DATA_W | Last word popped (registered) |
| pop_valid_o | output | 1 | One-cycle strobe: `pop_data_o` holds a new word |
| irq_en_i | input | 1 | Interrupt enable for the drain request |
| sreq_o | output | 1 | Drain request status flag |
| not_empty_o | output | 1 | At least one word is stored |
| dma_req_o | output | 1 | DMA service request (level) |
| irq_o | output | 1 | Interrupt request (level, masked) |
| overrun_o | output | 1 | One-cycle pulse when a push is dropped |

## Verification
The occupancy flags (`sreq_o`, `not_empty_o`, `dma_req_o`), the overrun pulse and the popped word all come from registers. They change on the edge that takes the push or pop, so the bench samples them one time unit after that edge. `irq_o` is combinational in `irq_en_i`, so after toggling the enable the bench checks it within the same cycle. A monitor on the falling edge compares every valid strobe against the head of the scoreboard queue. The driver adds a word to that queue only when its own occupancy model says the push is accepted.

// File: rtl/rx_fifo_pkg.sv
package rx_fifo_pkg;
  localparam int unsigned DFLT_DATA_W  = 32;
  localparam int unsigned DFLT_DEPTH   = 20;
  localparam int unsigned DFLT_SET_LVL = 12;
  localparam int unsigned DFLT_CLR_LVL = 11;

  typedef struct packed {
    logic wr;
    logic rd;
  } fifo_op_t;
endpackage

// File: rtl/rx_fifo_ctrl.sv
module rx_fifo_ctrl
  import rx_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = DFLT_DEPTH,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  output fifo_op_t         op_o,
  output logic [PTR_W-1:0] wr_ptr_o,
  output logic [PTR_W-1:0] rd_ptr_o,
  output logic [CNT_W-1:0] cnt_q_o,
  output logic [CNT_W-1:0] cnt_d_o,
  output logic             overrun_o
);
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             overrun_q;
  fifo_op_t         op;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_comb begin
    op.rd = pop_i && (cnt_q != '0);
    // full FIFO still takes a push when a word leaves in the same cycle
    op.wr = push_i && ((cnt_q != CNT_W'(DEPTH)) || op.rd);
    unique case ({op.wr, op.rd})
      2'b10:   cnt_d = cnt_q + CNT_W'(1);
      2'b01:   cnt_d = cnt_q - CNT_W'(1);
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q  <= '0;
      rd_ptr_q  <= '0;
      cnt_q     <= '0;
      overrun_q <= 1'b0;
    end else begin
      if (op.wr) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (op.rd) rd_ptr_q <= ptr_inc(rd_ptr_q);
      cnt_q     <= cnt_d;
      overrun_q <= push_i && !op.wr;
    end
  end

  assign op_o      = op;
  assign wr_ptr_o  = wr_ptr_q;
  assign rd_ptr_o  = rd_ptr_q;
  assign cnt_q_o   = cnt_q;
  assign cnt_d_o   = cnt_d;
  assign overrun_o = overrun_q;
endmodule

// File: rtl/rx_fifo_store.sv
module rx_fifo_store
  import rx_fifo_pkg::*;
#(
  parameter int unsigned DATA_W = DFLT_DATA_W,
  parameter int unsigned DEPTH  = DFLT_DEPTH,
  localparam int unsigned PTR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  fifo_op_t          op_i,
  input  logic [PTR_W-1:0]  wr_ptr_i,
  input  logic [PTR_W-1:0]  rd_ptr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DATA_W-1:0] rd_data_q;
  logic              rd_valid_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk_i) begin
      if (op_i.wr && (wr_ptr_i == PTR_W'(i))) mem_q[i] <= wr_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_data_q  <= '0;
      rd_valid_q <= 1'b0;
    end else begin
      rd_valid_q <= op_i.rd;
      if (op_i.rd) rd_data_q <= mem_q[rd_ptr_i];
    end
  end

  assign rd_data_o  = rd_data_q;
  assign rd_valid_o = rd_valid_q;
endmodule

// File: rtl/rx_fifo_flags.sv
module rx_fifo_flags
  import rx_fifo_pkg::*;
#(
  parameter int unsigned DEPTH   = DFLT_DEPTH,
  parameter int unsigned SET_LVL = DFLT_SET_LVL,
  parameter int unsigned CLR_LVL = DFLT_CLR_LVL,
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_d_i,
  input  logic             irq_en_i,
  output logic             sreq_o,
  output logic             not_empty_o,
  output logic             dma_req_o,
  output logic             irq_o
);
  logic sreq_q, nempty_q;

  // set and clear levels kept separate so hysteresis can be widened
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sreq_q   <= 1'b0;
      nempty_q <= 1'b0;
    end else begin
      if (cnt_d_i >= CNT_W'(SET_LVL))      sreq_q <= 1'b1;
      else if (cnt_d_i <= CNT_W'(CLR_LVL)) sreq_q <= 1'b0;
      nempty_q <= (cnt_d_i != '0);
    end
  end

  assign sreq_o      = sreq_q;
  assign not_empty_o = nempty_q;
  assign dma_req_o   = sreq_q;
  assign irq_o       = sreq_q && irq_en_i;
endmodule

// File: rtl/rx_fifo_sreq.sv
module rx_fifo_sreq
  import rx_fifo_pkg::*;
#(
  parameter int unsigned DATA_W  = DFLT_DATA_W,
  parameter int unsigned DEPTH   = DFLT_DEPTH,
  parameter int unsigned SET_LVL = DFLT_SET_LVL,
  parameter int unsigned CLR_LVL = DFLT_CLR_LVL
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] pop_data_o,
  output logic              pop_valid_o,
  input  logic              irq_en_i,
  output logic              sreq_o,
  output logic              not_empty_o,
  output logic              dma_req_o,
  output logic              irq_o,
  output logic              overrun_o
);
  localparam int unsigned PTR_W = $clog2(DEPTH);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  fifo_op_t         op;
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count_q, count_d;

  rx_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .push_i    (push_i),
    .pop_i     (pop_i),
    .op_o      (op),
    .wr_ptr_o  (wr_ptr),
    .rd_ptr_o  (rd_ptr),
    .cnt_q_o   (count_q),
    .cnt_d_o   (count_d),
    .overrun_o (overrun_o)
  );

  rx_fifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .op_i       (op),
    .wr_ptr_i   (wr_ptr),
    .rd_ptr_i   (rd_ptr),
    .wr_data_i  (push_data_i),
    .rd_data_o  (pop_data_o),
    .rd_valid_o (pop_valid_o)
  );

  rx_fifo_flags #(.DEPTH(DEPTH), .SET_LVL(SET_LVL), .CLR_LVL(CLR_LVL)) u_flags (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cnt_d_i     (count_d),
    .irq_en_i    (irq_en_i),
    .sreq_o      (sreq_o),
    .not_empty_o (not_empty_o),
    .dma_req_o   (dma_req_o),
    .irq_o       (irq_o)
  );
endmodule

// File: rtl/rx_fifo_sreq_chk.sv
module rx_fifo_sreq_chk #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned DEPTH   = 20,
  parameter int unsigned SET_LVL = 12,
  parameter int unsigned CLR_LVL = 11,
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              push_i,
  input logic              pop_i,
  input logic              irq_en_i,
  input logic [CNT_W-1:0]  count_i,
  input logic              sreq_i,
  input logic              not_empty_i,
  input logic              dma_req_i,
  input logic              irq_i,
  input logic              overrun_i,
  input logic              pop_valid_i,
  input logic [DATA_W-1:0] pop_data_i
);
  assert_level_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_i <= CNT_W'(DEPTH));
  assert_sreq_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_i >= CNT_W'(SET_LVL)) |-> sreq_i);
  assert_sreq_clr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_i <= CNT_W'(CLR_LVL)) |-> !sreq_i);
  assert_irq_implies_dma_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> dma_req_i);
  assert_irq_masked_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_en_i |-> !irq_i);
  assert_empty_flag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_i == '0) |-> !not_empty_i);
  assert_nonempty_flag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_i != '0) |-> not_empty_i);
  assert_overrun_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i && count_i == CNT_W'(DEPTH)) |=> (overrun_i && count_i == CNT_W'(DEPTH)));
  assert_pop_empty_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && count_i == '0) |=> (!pop_valid_i && $stable(pop_data_i)));
  assert_full_swap_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i && count_i == CNT_W'(DEPTH)) |=> (!overrun_i && count_i == CNT_W'(DEPTH)));
endmodule

bind rx_fifo_sreq rx_fifo_sreq_chk #(
  .DATA_W(DATA_W), .DEPTH(DEPTH), .SET_LVL(SET_LVL), .CLR_LVL(CLR_LVL)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .push_i      (push_i),
  .pop_i       (pop_i),
  .irq_en_i    (irq_en_i),
  .count_i     (count_q),
  .sreq_i      (sreq_o),
  .not_empty_i (not_empty_o),
  .dma_req_i   (dma_req_o),
  .irq_i       (irq_o),
  .overrun_i   (overrun_o),
  .pop_valid_i (pop_valid_o),
  .pop_data_i  (pop_data_o)
);

// File: tb/rx_fifo_sreq_test.sv
module rx_fifo_sreq_test;
  localparam int DW = 32;
  localparam int DEPTH = 20;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic push_i = 1'b0, pop_i = 1'b0, irq_en_i = 1'b0;
  logic [DW-1:0] push_data_i = '0;
  logic [DW-1:0] pop_data_o;
  logic pop_valid_o, sreq_o, not_empty_o, dma_req_o, irq_o, overrun_o;

  rx_fifo_sreq uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .push_i(push_i), .push_data_i(push_data_i),
    .pop_i(pop_i), .pop_data_o(pop_data_o), .pop_valid_o(pop_valid_o),
    .irq_en_i(irq_en_i), .sreq_o(sreq_o), .not_empty_o(not_empty_o),
    .dma_req_o(dma_req_o), .irq_o(irq_o), .overrun_o(overrun_o)
  );

  always #2.5 clk_i = ~clk_i;

  int n_run = 0, n_fail = 0;
  int model_cnt = 0;
  logic exp_pop = 1'b0;
  logic [DW-1:0] sb_q[$];
  logic done = 1'b0;

  task automatic check(input logic ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: compares popped words against the scoreboard
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      check(pop_valid_o == exp_pop, "R2 pop_valid", DW'(pop_valid_o), DW'(exp_pop));
      if (pop_valid_o && sb_q.size() > 0) begin
        logic [DW-1:0] e;
        e = sb_q.pop_front();
        check(pop_data_o == e, "R2 order", pop_data_o, e);
      end
    end
  end

  // driver: one cycle of stimulus, flags checked after the edge
  task automatic step(input logic psh, input logic [DW-1:0] d, input logic pp);
    logic rd_ok, wr_ok;
    @(negedge clk_i);
    push_i = psh; push_data_i = d; pop_i = pp;
    rd_ok = pp && (model_cnt > 0);
    wr_ok = psh && ((model_cnt < DEPTH) || rd_ok);
    @(posedge clk_i);
    #1;
    exp_pop = rd_ok;
    if (wr_ok) sb_q.push_back(d);
    model_cnt = model_cnt + int'(wr_ok) - int'(rd_ok);
    check(not_empty_o == (model_cnt > 0), "R7 not_empty", DW'(not_empty_o), DW'(model_cnt > 0));
    check(sreq_o == (model_cnt >= 12), "R3/R4 sreq", DW'(sreq_o), DW'(model_cnt >= 12));
    check(dma_req_o == sreq_o, "R5 dma", DW'(dma_req_o), DW'(sreq_o));
    check(irq_o == (sreq_o && irq_en_i), "R6 irq", DW'(irq_o), DW'(sreq_o && irq_en_i));
    check(overrun_o == (psh && !wr_ok), "R8 overrun", DW'(overrun_o), DW'(psh && !wr_ok));
    push_i = 1'b0; pop_i = 1'b0;
  endtask

  initial begin
    #1000000;
    n_run++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [DW-1:0] held;
    #12;
    // R1: reset state
    check(!not_empty_o && !sreq_o && !dma_req_o && !irq_o && !overrun_o && !pop_valid_o,
          "R1 reset", DW'({not_empty_o, sreq_o, dma_req_o, irq_o, overrun_o, pop_valid_o}), '0);
    @(negedge clk_i); rst_ni = 1'b1;
    irq_en_i = 1'b1;
    // R3: fill up to the request level
    for (int i = 0; i < 12; i++) step(1'b1, 32'hA500_0000 + DW'(i), 1'b0);
    check(sreq_o && dma_req_o && irq_o, "R3 request at 12", DW'({sreq_o, dma_req_o, irq_o}), 3'b111);
    // R5/R6: mask drops interrupt only, same cycle
    irq_en_i = 1'b0; #1;
    check(!irq_o, "R6 masked irq", DW'(irq_o), 0);
    check(dma_req_o, "R5 dma unmasked", DW'(dma_req_o), 1);
    irq_en_i = 1'b1; #1;
    check(irq_o, "R6 unmasked irq", DW'(irq_o), 1);
    // fill to full, then overrun (R8)
    for (int i = 12; i < DEPTH; i++) step(1'b1, 32'h5A00_0000 + DW'(i), 1'b0);
    step(1'b1, 32'hDEAD_BEEF, 1'b0);
    check(overrun_o, "R8 overrun pulse", DW'(overrun_o), 1);
    step(1'b0, '0, 1'b0);
    check(!overrun_o, "R8 pulse one cycle", DW'(overrun_o), 0);
    // R10: push and pop together while full
    step(1'b1, 32'h1234_5678, 1'b1);
    check(!overrun_o && model_cnt == DEPTH, "R10 full swap", DW'(overrun_o), 0);
    // R4: drain down through the clear level
    while (model_cnt > 12) step(1'b0, '0, 1'b1);
    check(sreq_o, "R4 still set at 12", DW'(sreq_o), 1);
    step(1'b0, '0, 1'b1);
    check(!sreq_o && !dma_req_o && !irq_o, "R4 clear at 11", DW'({sreq_o, dma_req_o, irq_o}), 0);
    // interleaved push/pop with data pattern (R2)
    for (int i = 0; i < 6; i++) step(1'b1, ~DW'(i * 32'h0101_0101), i[0]);
    // drain fully (R7)
    while (model_cnt > 0) step(1'b0, '0, 1'b1);
    step(1'b0, '0, 1'b0);
    check(!not_empty_o, "R7 empty after drain", DW'(not_empty_o), 0);
    // R9: pop on empty
    held = pop_data_o;
    step(1'b0, '0, 1'b1);
    check(!pop_valid_o && pop_data_o == held, "R9 pop empty held", pop_data_o, held);
    check(!not_empty_o, "R9 state unchanged", DW'(not_empty_o), 0);
    // push+pop on empty: only the push lands
    step(1'b1, 32'h0F0F_0F0F, 1'b1);
    check(not_empty_o, "R9 push lands", DW'(not_empty_o), 1);
    step(1'b0, '0, 1'b1);
    step(1'b0, '0, 1'b0);
    check(sb_q.size() == 0, "R2 scoreboard drained", DW'(sb_q.size()), 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule